// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point operands in the common single-precision interchange format. Each word has a sign in bit 31, a biased exponent (bias 127) in bits 30:23 and a fraction in bits 22:0. A normal value is (-1)^s x (1.fraction) x 2^(exp-127). The `sub` input selects subtraction. Subtraction is carried out by inverting the sign of the second operand before the add-or-subtract decision is made.

Operands are accepted when `in_valid` and `in_ready` are both high. The result appears in a single output register one clock later, and it is held there until the consumer takes it with `out_ready`. The arithmetic is completed within the cycle of acceptance: restore the hidden bit, align the smaller operand while keeping guard, round and sticky bits, add or subtract the significands, normalize, round to nearest even, renormalize if rounding carries out, and pack. Operands with exponent 0 count as zero, so subnormals are flushed. The only exception flag is `invalid`.

Top module: `fp32_adder`

## Requirements
- R1: For finite normal operands, `result` is the exact sum rounded to nearest. On a tie the result has an even fraction LSB (bit 0).
- R2: When `sub` is 1, the result equals the sum of `op_a` and `op_b` with bit 31 of `op_b` inverted.
- R3: An accepted operand pair (`in_valid` and `in_ready` high at a rising edge) gives `out_valid` = 1 after exactly one edge. While `out_valid` = 1 and `out_ready` = 0, `result` and `invalid` hold and `in_ready` is 0. After reset, `out_valid` = 0 and `in_ready` = 1.
- R4: When the operands cancel exactly, the result is +0 (0x00000000).
- R5: Any NaN operand (exponent 255, fraction nonzero) gives 0x7FC00000 with `invalid` = 0.
- R6: Two infinities of opposite effective sign give 0x7FC00000 with `invalid` = 1. `invalid` is 0 in every other case.
- R7: When exactly one operand is infinite, or both are with the same effective sign, the result is infinity (exponent 255, fraction 0) with that operand's effective sign.
- R8: A rounded result whose exponent reaches 255 or above becomes infinity with the result's sign.
- R9: A rounded result whose biased exponent is 0 or below becomes a zero with the result's sign. An operand with exponent 0 is treated as zero whatever its fraction.
- R10: When one operand is zero, the result is the other operand with its effective sign. When both are zero, the result is -0 only if both effective signs are negative, and +0 otherwise.
- R11: When rounding carries out of the significand, the result is renormalized: the fraction becomes 0 and the exponent goes up by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can accept an operand pair |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub | input | 1 | 1 = subtract `op_b` from `op_a` |
| out_valid | output | 1 | `result` holds an untaken value |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Rounded sum or difference |
| invalid | output | 1 | Result comes from an invalid operation |

## Verification
Four random families are used. Full-range random words reach the special encodings and the overflow and flush limits. Unrelated normal operands mostly exercise far alignment and sticky collection. Operands with nearby exponents mix right-shift normalization on sums with one-step left shifts on differences. Near-copies of the same operand with opposite effective sign force deep left shifts and exact cancellation. Directed cases target specific boundaries: ties that round down to even and ties that round up, a rounding carry that renormalizes, signed zero pairs, infinity against infinity, and back-pressure held over several cycles.

// File: rtl/fp32_adder.sv
module fp32_adder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        sub,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] result,
  output logic        invalid
);
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  logic        sa, sb;
  logic [7:0]  ea, eb;
  logic [22:0] fa, fb;
  assign sa = op_a[31];
  assign sb = op_b[31] ^ sub;
  assign ea = op_a[30:23];
  assign eb = op_b[30:23];
  assign fa = op_a[22:0];
  assign fb = op_b[22:0];

  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  assign a_zero = (ea == 8'd0);
  assign b_zero = (eb == 8'd0);
  assign a_inf  = (ea == 8'hFF) && (fa == 23'd0);
  assign b_inf  = (eb == 8'hFF) && (fb == 23'd0);
  assign a_nan  = (ea == 8'hFF) && (fa != 23'd0);
  assign b_nan  = (eb == 8'hFF) && (fb != 23'd0);

  logic        a_big, sl, ss;
  logic [7:0]  el, es, dexp;
  logic [22:0] fl, fs;
  assign a_big = op_a[30:0] >= op_b[30:0];
  assign sl    = a_big ? sa : sb;
  assign ss    = a_big ? sb : sa;
  assign el    = a_big ? ea : eb;
  assign es    = a_big ? eb : ea;
  assign fl    = a_big ? fa : fb;
  assign fs    = a_big ? fb : fa;
  assign dexp  = el - es;

  logic [4:0]  shamt;
  logic [49:0] wide;
  logic [26:0] big_x, small_x;
  logic [27:0] sum;
  assign shamt   = (dexp > 8'd31) ? 5'd31 : dexp[4:0];
  assign wide    = {1'b1, fs, 26'd0} >> shamt;
  assign big_x   = {1'b1, fl, 3'b000};
  assign small_x = {wide[49:24], |wide[23:0]};
  assign sum     = (sl ^ ss) ? {1'b0, big_x} - {1'b0, small_x}
                             : {1'b0, big_x} + {1'b0, small_x};

  logic [4:0] lz;
  always_comb begin
    lz = 5'd0;
    for (int i = 0; i < 27; i++)
      if (sum[i]) lz = 5'(26 - i);
  end

  logic [26:0]       norm;
  logic signed [9:0] enorm;
  always_comb begin
    if (sum[27]) begin
      norm  = {sum[27:2], sum[1] | sum[0]};
      enorm = $signed({2'b00, el}) + 10'sd1;
    end else begin
      norm  = sum[26:0] << lz;
      enorm = $signed({2'b00, el}) - $signed({5'd0, lz});
    end
  end

  logic              up;
  logic [24:0]       rnd;
  logic signed [9:0] efin;
  logic [22:0]       ffin;
  assign up   = norm[2] & (norm[1] | norm[0] | norm[3]);
  assign rnd  = {1'b0, norm[26:3]} + {24'd0, up};
  assign efin = enorm + $signed({9'd0, rnd[24]});
  assign ffin = rnd[24] ? rnd[23:1] : rnd[22:0];

  logic [31:0] nxt;
  logic        nxt_inv;
  always_comb begin
    nxt_inv = 1'b0;
    if (a_nan || b_nan)                  nxt = QNAN;
    else if (a_inf && b_inf && (sa ^ sb)) begin
      nxt = QNAN;
      nxt_inv = 1'b1;
    end
    else if (a_inf)                      nxt = {sa, 8'hFF, 23'd0};
    else if (b_inf)                      nxt = {sb, 8'hFF, 23'd0};
    else if (a_zero && b_zero)           nxt = {sa & sb, 31'd0};
    else if (a_zero)                     nxt = {sb, op_b[30:0]};
    else if (b_zero)                     nxt = op_a;
    else if (sum == 28'd0)               nxt = 32'd0;
    else if (efin >= 10'sd255)           nxt = {sl, 8'hFF, 23'd0};
    else if (efin <= 10'sd0)             nxt = {sl, 31'd0};
    else                                 nxt = {sl, efin[7:0], ffin};
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 32'd0;
      invalid   <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) begin
        result  <= nxt;
        invalid <= nxt_inv;
      end
    end
  end
endmodule

// File: rtl/fp32_adder_chk.sv
module fp32_adder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] result,
  input logic        invalid
);
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R3
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(invalid)); // R3
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R3
  AST_NAN_PROPAGATE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_a[30:23] == 8'hFF && op_a[22:0] != 23'd0
    |=> result == 32'h7FC0_0000 && !invalid); // R5
  AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && invalid |-> result == 32'h7FC0_0000); // R6
  AST_NAN_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && result[30:23] == 8'hFF && result[22:0] != 23'd0
    |-> result == 32'h7FC0_0000); // R5
  AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && result[30:23] == 8'd0 && !(in_valid && in_ready)
    |-> result[22:0] == 23'd0 || $past(op_a[30:23] == 8'd0)); // R9
endmodule

bind fp32_adder fp32_adder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
  .result(result), .invalid(invalid)
);

// File: tb/fp32_adder_tb_top.sv
`timescale 1ns/1ps
module fp32_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        sub = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] result;
  logic        invalid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp32_adder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .sub(sub), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .invalid(invalid)
  );

  function automatic logic [32:0] ref_add(logic [31:0] a, logic [31:0] b, logic s);
    logic sa, sb, sl, ss, sg;
    int ea, eb, el, es, d, base, p, k, ex;
    logic [127:0] ml, ms, x, y, m, q, rem, half;
    sa = a[31]; sb = b[31] ^ s;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return {1'b0, 32'h7FC0_0000};
    if (ea == 255 && eb == 255) return (sa != sb) ? {1'b1, 32'h7FC0_0000} : {1'b0, sa, 8'hFF, 23'd0};
    if (ea == 255) return {1'b0, sa, 8'hFF, 23'd0};
    if (eb == 255) return {1'b0, sb, 8'hFF, 23'd0};
    if (ea == 0 && eb == 0) return {1'b0, sa & sb, 31'd0};
    if (ea == 0) return {1'b0, sb, b[30:0]};
    if (eb == 0) return {1'b0, a};
    if (ea >= eb) begin
      sl = sa; ss = sb; el = ea; es = eb;
      ml = {104'd0, 1'b1, a[22:0]}; ms = {104'd0, 1'b1, b[22:0]};
    end else begin
      sl = sb; ss = sa; el = eb; es = ea;
      ml = {104'd0, 1'b1, b[22:0]}; ms = {104'd0, 1'b1, a[22:0]};
    end
    d = el - es;
    if (d <= 60) begin x = ml << d; y = ms; base = es; end
    else begin x = ml << 60; y = 128'd1; base = el - 60; end
    if (sl == ss) begin m = x + y; sg = sl; end
    else if (x >= y) begin m = x - y; sg = sl; end
    else begin m = y - x; sg = ss; end
    if (m == 0) return 33'd0;
    p = 0;
    for (int i = 0; i < 128; i++) if (m[i]) p = i;
    if (p > 23) begin
      k = p - 23;
      q = m >> k;
      rem = m & ((128'd1 << k) - 128'd1);
      half = 128'd1 << (k - 1);
      if (rem > half || (rem == half && q[0])) q = q + 128'd1;
      if (q[24]) begin q = q >> 1; k = k + 1; end
      ex = base + k;
    end else begin
      q = m << (23 - p);
      ex = base - (23 - p);
    end
    if (ex >= 255) return {1'b0, sg, 8'hFF, 23'd0};
    if (ex <= 0) return {1'b0, sg, 31'd0};
    return {1'b0, sg, ex[7:0], q[22:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic run(logic [31:0] a, logic [31:0] b, logic s, string req,
                     logic [31:0] exp, logic exp_inv, int stall);
    @(negedge clk);
    op_a = a; op_b = b; sub = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R3 out_valid after accept"}, {31'd0, out_valid}, 32'd1);
    check(req, result, exp);
    check({req, " invalid"}, {31'd0, invalid}, {31'd0, exp_inv});
    for (int i = 0; i < stall; i++) begin
      op_a = 32'h7F80_0001; op_b = 32'h3F80_0000; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R3 held result", result, exp);
      check("R3 in_ready low while held", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R3 out_valid cleared after take", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic run_ref(logic [31:0] a, logic [31:0] b, logic s, string req, int stall);
    logic [32:0] r;
    r = ref_add(a, b, s);
    run(a, b, s, req, r[31:0], r[32], stall);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    logic s;
    int unsigned mode;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R3 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R3 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    run(32'h3F80_0000, 32'h3F80_0000, 1'b0, "R1 one plus one", 32'h4000_0000, 1'b0, 0);
    run(32'h4040_0000, 32'h3F80_0000, 1'b1, "R2 three minus one", 32'h4000_0000, 1'b0, 2);
    run(32'h3F80_0000, 32'h3F80_0000, 1'b1, "R4 x minus x", 32'h0000_0000, 1'b0, 0);
    run(32'hC120_0000, 32'h4120_0000, 1'b0, "R4 cancel negative first", 32'h0000_0000, 1'b0, 0);
    run(32'h7F80_0001, 32'h3F80_0000, 1'b0, "R5 nan a", 32'h7FC0_0000, 1'b0, 0);
    run(32'h3F80_0000, 32'hFFC0_1234, 1'b1, "R5 nan b", 32'h7FC0_0000, 1'b0, 0);
    run(32'h7F80_0000, 32'h7F80_0000, 1'b1, "R6 inf minus inf", 32'h7FC0_0000, 1'b1, 1);
    run(32'h7F80_0000, 32'hFF80_0000, 1'b0, "R6 inf plus neg inf", 32'h7FC0_0000, 1'b1, 0);
    run(32'h7F80_0000, 32'h7F80_0000, 1'b0, "R7 inf plus inf", 32'h7F80_0000, 1'b0, 0);
    run(32'h3F80_0000, 32'h7F80_0000, 1'b1, "R7 one minus inf", 32'hFF80_0000, 1'b0, 0);
    run(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, "R8 max plus max", 32'h7F80_0000, 1'b0, 0);
    run(32'hFF7F_FFFF, 32'h7F7F_FFFF, 1'b1, "R8 neg overflow", 32'hFF80_0000, 1'b0, 0);
    run(32'h8080_0001, 32'h8080_0000, 1'b1, "R9 flush to neg zero", 32'h8000_0000, 1'b0, 0);
    run(32'h0000_0005, 32'h3F80_0000, 1'b0, "R9 subnormal operand as zero", 32'h3F80_0000, 1'b0, 0);
    run(32'h8000_0000, 32'h8000_0000, 1'b0, "R10 neg zero plus neg zero", 32'h8000_0000, 1'b0, 0);
    run(32'h8000_0000, 32'h8000_0000, 1'b1, "R10 neg zero minus neg zero", 32'h0000_0000, 1'b0, 0);
    run(32'h0000_0000, 32'h4040_0000, 1'b1, "R10 zero minus three", 32'hC040_0000, 1'b0, 0);
    run(32'h3F7F_FFFF, 32'h3300_0000, 1'b0, "R11 tie carry renormalize", 32'h3F80_0000, 1'b0, 0);
    run(32'h3F80_0000, 32'h3380_0000, 1'b0, "R1 tie stays even", 32'h3F80_0000, 1'b0, 0);
    run(32'h3F80_0001, 32'h3380_0000, 1'b0, "R1 tie rounds to even", 32'h3F80_0002, 1'b0, 0);

    for (int n = 0; n < 3000; n++) begin
      mode = $urandom % 4;
      s = 1'($urandom);
      a = {1'($urandom), 8'(1 + ($urandom % 254)), 23'($urandom)};
      case (mode)
        0: b = {1'($urandom), 8'(1 + ($urandom % 254)), 23'($urandom)};
        1: b = {1'($urandom), 8'(int'(a[30:23]) > 3 ? int'(a[30:23]) - ($urandom % 4) : 1), 23'($urandom)};
        2: b = {a[31] ^ ~s, a[30:0] ^ 31'($urandom % 64)};
        default: begin a = $urandom; b = $urandom; end
      endcase
      run_ref(a, b, s, s ? "R2 random subtract" : "R1 random add", int'($urandom % 2));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule